// File: doc/BRIEF.md
# Programmable Static Memory Strobe Timing Generator

This block drives one asynchronous static memory device. For every access it produces an active-low chip select and an active-low output enable (reads) or write enable (writes). Each strobe rises and falls at points counted in system clock ticks from the start of the access: a setup length before the strobe falls, a pulse length while it is low, and a total cycle length for the whole access. The strobe timing, the read capture point, the write completion point and an idle gap after each read are all programmable through a small configuration register port.

A host issues read or write requests over a valid/ready handshake. For the length of an access the block holds the address and, on writes, the output data with its drive enable. On reads it samples the memory data bus at a selectable strobe edge and returns the sampled byte with a one-tick valid pulse. On writes the same response pulse marks the point where the memory has latched the data. A pulse length of zero is illegal: the block raises a configuration error flag and runs such a pulse as one tick.

Top module: `sram_strobe_ctl`

## Requirements
- R1: On a read accepted at clock edge E, tick k is the clock period that starts k edges after E (tick 0 starts at E). The chip select is low exactly in ticks cs_setup .. cs_setup+cs_pulse-1. The output enable is low exactly in ticks rd_setup .. rd_setup+rd_pulse-1. Write enable stays high.
- R2: A write follows the same rule with the write-side chip-select fields and the write-enable fields. Output enable stays high, and output enable and write enable are never low together.
- R3: The cycle field is decoded as field[8:7]*256 + field[6:0]. An access lasts max(decoded cycle, chip-select end, strobe end) ticks, so every strobe is high again in tick "length". This covers the case where the decoded cycle is 0 or shorter than setup plus pulse.
- R4: `cfg_err` is 1 exactly while any of the four pulse fields (chip select and strobe, for both reads and writes) is zero. A zero pulse is run as a pulse of 1 tick.
- R5: MODE bit 8 selects the read capture point. With 1, read data is sampled at the end of the last output-enable-low tick. With 0, it is sampled at the end of the last chip-select-low tick. `rsp_valid` is high for exactly the one tick after the sample, and `rsp_rdata` holds the sampled value.
- R6: MODE bit 9 selects the write completion point. With 1 it follows write enable; with 0 it follows chip select. `rsp_valid` is high for exactly the tick in which the selected strobe has just returned high.
- R7: On a write, `mem_dout_en` is 1 and `mem_dout` equals the request data from tick 0 through the tick after the last access tick. `mem_addr` equals the request address throughout the access.
- R8: After a read, `req_ready` stays low for MODE[3:0] further idle ticks past the access. After a write, no such ticks are added.
- R9: `req_ready` is high only when the block is idle. It goes low in tick 0 of an accepted access and returns high in tick length+float, where float is 0 for writes.
- R10: After reset, all strobes are high, `mem_dout_en` and `rsp_valid` are 0, `req_ready` is 1 and `cfg_err` is 0. The reset configuration has all setups 0, all pulses 1, cycles 0, float 0 and both MODE select bits at 1.
- R11: `mem_dout_en` is never 1 while output enable is low.
- R12: Configuration registers (index on `cfg_addr`, written when `cfg_wr` is high): 0 read setup, 1 read pulse, 3 write setup, 4 write pulse. In each of these, the strobe value is in bits [SETUP_W-1:0] or [PULSE_W-1:0] and the chip-select value starts at bit 8. Registers 2 and 5 hold the read and write cycle fields in bits [8:0]. Register 6 is MODE: float count in [3:0], read select in bit 8, write select in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_err | output | 1 | A pulse field holds the illegal value zero |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | One-tick pulse: read data ready or write latched |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Memory data out |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W | Memory data in |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
Every strobe is a register loaded at the edge that opens a tick, so in tick k the bench expects each strobe value computed from the programmed fields for offset k. It samples at the falling edge inside that tick, counting tick 0 as the period that begins at the accepting edge. The response pulse is due one tick after the chosen capture or completion tick. `req_ready` is due back exactly length plus float ticks after acceptance, and `cfg_err` is due in the first tick after the write that changes a pulse field. The bench memory model returns the address XOR the number of ticks output enable has been low, so the captured byte shows which tick was sampled.

// File: rtl/sram_tim_pkg.sv
package sram_tim_pkg;

   localparam int CFG_W       = 16;
   localparam int CYC_FIELD_W = 9;
   localparam int CYC_DEC_W   = 10;
   localparam int CS_LSB      = 8;
   localparam int MODE_RD_BIT = 8;
   localparam int MODE_WR_BIT = 9;
   localparam int N_KIND      = 2;   // 0 = read, 1 = write

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_FLT  = 2'd2
   } seq_st_e;

   // split cycle encoding: upper two bits weigh 256 each step
   function automatic logic [CYC_DEC_W-1:0] cyc_decode(input logic [CYC_FIELD_W-1:0] f);
      return ({8'd0, f[8:7]} << 8) + {3'd0, f[6:0]};
   endfunction

endpackage

// File: rtl/smt_cfg_regs.sv
module smt_cfg_regs
   import sram_tim_pkg::*;
#(
   parameter int SETUP_W = 6,
   parameter int PULSE_W = 6,
   parameter int FLOAT_W = 4
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     cfg_wr,
   input  logic [2:0]                               cfg_addr,
   input  logic [CFG_W-1:0]                         cfg_wdata,
   output logic [N_KIND-1:0][SETUP_W-1:0]           cs_setup,
   output logic [N_KIND-1:0][PULSE_W-1:0]           cs_pulse,
   output logic [N_KIND-1:0][SETUP_W-1:0]           st_setup,
   output logic [N_KIND-1:0][PULSE_W-1:0]           st_pulse,
   output logic [N_KIND-1:0][CYC_FIELD_W-1:0]       cyc_field,
   output logic [N_KIND-1:0]                        on_strobe,
   output logic [FLOAT_W-1:0]                       float_ticks,
   output logic                                     cfg_err
);

   localparam logic [2:0] A_MODE = 3'd6;

   for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      localparam logic [2:0] A_SET = 3'(k * 3);
      localparam logic [2:0] A_PUL = 3'(k * 3 + 1);
      localparam logic [2:0] A_CYC = 3'(k * 3 + 2);

      logic [SETUP_W-1:0]     cs_s_q, st_s_q;
      logic [PULSE_W-1:0]     cs_p_q, st_p_q;
      logic [CYC_FIELD_W-1:0] cyc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_s_q <= '0;
            st_s_q <= '0;
            cs_p_q <= PULSE_W'(1);
            st_p_q <= PULSE_W'(1);
            cyc_q  <= '0;
         end else if (cfg_wr) begin
            if (cfg_addr == A_SET) begin
               st_s_q <= cfg_wdata[SETUP_W-1:0];
               cs_s_q <= cfg_wdata[CS_LSB +: SETUP_W];
            end
            if (cfg_addr == A_PUL) begin
               st_p_q <= cfg_wdata[PULSE_W-1:0];
               cs_p_q <= cfg_wdata[CS_LSB +: PULSE_W];
            end
            if (cfg_addr == A_CYC) begin
               cyc_q <= cfg_wdata[CYC_FIELD_W-1:0];
            end
         end
      end

      assign cs_setup[k]  = cs_s_q;
      assign st_setup[k]  = st_s_q;
      assign cs_pulse[k]  = cs_p_q;
      assign st_pulse[k]  = st_p_q;
      assign cyc_field[k] = cyc_q;
   end

   logic [FLOAT_W-1:0] flt_q;
   logic [1:0]         sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_q <= '0;
         sel_q <= 2'b11;
      end else if (cfg_wr && cfg_addr == A_MODE) begin
         flt_q <= cfg_wdata[FLOAT_W-1:0];
         sel_q <= {cfg_wdata[MODE_WR_BIT], cfg_wdata[MODE_RD_BIT]};
      end
   end

   assign float_ticks = flt_q;
   assign on_strobe   = sel_q;

   always_comb begin
      cfg_err = 1'b0;
      for (int k = 0; k < N_KIND; k++) begin
         if (cs_pulse[k] == '0 || st_pulse[k] == '0) cfg_err = 1'b1;
      end
   end

endmodule

// File: rtl/smt_acc_calc.sv
module smt_acc_calc
   import sram_tim_pkg::*;
#(
   parameter int SETUP_W = 6,
   parameter int PULSE_W = 6,
   parameter int CNT_W   = 10
) (
   input  logic [SETUP_W-1:0]     cs_setup,
   input  logic [PULSE_W-1:0]     cs_pulse,
   input  logic [SETUP_W-1:0]     st_setup,
   input  logic [PULSE_W-1:0]     st_pulse,
   input  logic [CYC_FIELD_W-1:0] cyc_field,
   input  logic                   evt_on_strobe,
   output logic [CNT_W-1:0]       cs_on,
   output logic [CNT_W-1:0]       cs_off,
   output logic [CNT_W-1:0]       st_on,
   output logic [CNT_W-1:0]       st_off,
   output logic [CNT_W-1:0]       last,
   output logic [CNT_W-1:0]       evt
);

   logic [CNT_W-1:0] cs_pe, st_pe, cyc, span;

   always_comb begin
      // an illegal zero pulse runs as one tick
      cs_pe  = (cs_pulse == '0) ? CNT_W'(1) : CNT_W'(cs_pulse);
      st_pe  = (st_pulse == '0) ? CNT_W'(1) : CNT_W'(st_pulse);
      cs_on  = CNT_W'(cs_setup);
      st_on  = CNT_W'(st_setup);
      cs_off = cs_on + cs_pe;
      st_off = st_on + st_pe;
      cyc    = CNT_W'(cyc_decode(cyc_field));
      span   = cyc;
      if (cs_off > span) span = cs_off;
      if (st_off > span) span = st_off;
      last   = span - CNT_W'(1);
      evt    = (evt_on_strobe ? st_off : cs_off) - CNT_W'(1);
   end

endmodule

// File: rtl/smt_seq.sv
module smt_seq
   import sram_tim_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int FLOAT_W = 4,
   parameter int CNT_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               req_ready,
   input  logic [CNT_W-1:0]   cs_on,
   input  logic [CNT_W-1:0]   cs_off,
   input  logic [CNT_W-1:0]   st_on,
   input  logic [CNT_W-1:0]   st_off,
   input  logic [CNT_W-1:0]   last,
   input  logic [CNT_W-1:0]   evt,
   input  logic [FLOAT_W-1:0] float_ticks,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_dout,
   output logic               mem_dout_en,
   input  logic [DATA_W-1:0]  mem_din,
   output logic               mem_cs_n,
   output logic               mem_oe_n,
   output logic               mem_we_n
);

   function automatic logic in_win(input logic [CNT_W-1:0] x,
                                   input logic [CNT_W-1:0] on,
                                   input logic [CNT_W-1:0] off);
      return (x >= on) && (x < off);
   endfunction

   seq_st_e            st;
   logic [CNT_W-1:0]   t, t_nx;
   logic [CNT_W-1:0]   r_cs_on, r_cs_off, r_st_on, r_st_off, r_last, r_evt;
   logic [FLOAT_W-1:0] r_float, fcnt;
   logic               is_wr;
   logic               acc;

   assign req_ready = (st == ST_IDLE);
   assign acc       = req_valid && req_ready;
   assign t_nx      = t + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         t           <= '0;
         fcnt        <= '0;
         r_float     <= '0;
         is_wr       <= 1'b0;
         r_cs_on     <= '0;
         r_cs_off    <= '0;
         r_st_on     <= '0;
         r_st_off    <= '0;
         r_last      <= '0;
         r_evt       <= '0;
         mem_addr    <= '0;
         mem_dout    <= '0;
         mem_dout_en <= 1'b0;
         mem_cs_n    <= 1'b1;
         mem_oe_n    <= 1'b1;
         mem_we_n    <= 1'b1;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               // write data hold tick ends here unless a new write begins
               mem_dout_en <= acc && req_write;
               if (acc) begin
                  st       <= ST_ACC;
                  t        <= '0;
                  is_wr    <= req_write;
                  mem_addr <= req_addr;
                  if (req_write) mem_dout <= req_wdata;
                  r_cs_on  <= cs_on;
                  r_cs_off <= cs_off;
                  r_st_on  <= st_on;
                  r_st_off <= st_off;
                  r_last   <= last;
                  r_evt    <= evt;
                  r_float  <= float_ticks;
                  mem_cs_n <= !in_win('0, cs_on, cs_off);
                  mem_oe_n <= req_write || !in_win('0, st_on, st_off);
                  mem_we_n <= !req_write || !in_win('0, st_on, st_off);
               end
            end
            ST_ACC: begin
               if (t == r_evt) begin
                  rsp_valid <= 1'b1;
                  if (!is_wr) rsp_rdata <= mem_din;
               end
               if (t == r_last) begin
                  mem_cs_n <= 1'b1;
                  mem_oe_n <= 1'b1;
                  mem_we_n <= 1'b1;
                  if (!is_wr && r_float != '0) begin
                     st   <= ST_FLT;
                     fcnt <= r_float;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  t        <= t_nx;
                  mem_cs_n <= !in_win(t_nx, r_cs_on, r_cs_off);
                  mem_oe_n <= is_wr || !in_win(t_nx, r_st_on, r_st_off);
                  mem_we_n <= !is_wr || !in_win(t_nx, r_st_on, r_st_off);
               end
            end
            ST_FLT: begin
               fcnt <= fcnt - FLOAT_W'(1);
               if (fcnt == FLOAT_W'(1)) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
   import sram_tim_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int SETUP_W = 6,
   parameter int PULSE_W = 6,
   parameter int FLOAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_addr,
   input  logic [15:0]       cfg_wdata,
   output logic              cfg_err,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);

   localparam int CYC_MAX  = 3 * 256 + 127;
   localparam int SP_MAX   = ((1 << SETUP_W) - 1) + ((1 << PULSE_W) - 1);
   localparam int SPAN_MAX = (CYC_MAX > SP_MAX) ? CYC_MAX : SP_MAX;
   localparam int CNT_W    = $clog2(SPAN_MAX + 2);

   if (SETUP_W < 1 || SETUP_W > 8) begin : g_bad_setup
      $error("SETUP_W must lie in 1..8");
   end
   if (PULSE_W < 1 || PULSE_W > 8) begin : g_bad_pulse
      $error("PULSE_W must lie in 1..8");
   end
   if (FLOAT_W < 1 || FLOAT_W > 8) begin : g_bad_float
      $error("FLOAT_W must lie in 1..8");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("bus widths must be positive");
   end

   logic [N_KIND-1:0][SETUP_W-1:0]     cs_setup, st_setup;
   logic [N_KIND-1:0][PULSE_W-1:0]     cs_pulse, st_pulse;
   logic [N_KIND-1:0][CYC_FIELD_W-1:0] cyc_field;
   logic [N_KIND-1:0]                  on_strobe;
   logic [FLOAT_W-1:0]                 float_ticks;

   smt_cfg_regs #(
      .SETUP_W(SETUP_W), .PULSE_W(PULSE_W), .FLOAT_W(FLOAT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cs_setup   (cs_setup),
      .cs_pulse   (cs_pulse),
      .st_setup   (st_setup),
      .st_pulse   (st_pulse),
      .cyc_field  (cyc_field),
      .on_strobe  (on_strobe),
      .float_ticks(float_ticks),
      .cfg_err    (cfg_err)
   );

   logic [N_KIND-1:0][CNT_W-1:0] k_cs_on, k_cs_off, k_st_on, k_st_off, k_last, k_evt;

   for (genvar k = 0; k < N_KIND; k++) begin : g_calc
      smt_acc_calc #(
         .SETUP_W(SETUP_W), .PULSE_W(PULSE_W), .CNT_W(CNT_W)
      ) u_calc (
         .cs_setup     (cs_setup[k]),
         .cs_pulse     (cs_pulse[k]),
         .st_setup     (st_setup[k]),
         .st_pulse     (st_pulse[k]),
         .cyc_field    (cyc_field[k]),
         .evt_on_strobe(on_strobe[k]),
         .cs_on        (k_cs_on[k]),
         .cs_off       (k_cs_off[k]),
         .st_on        (k_st_on[k]),
         .st_off       (k_st_off[k]),
         .last         (k_last[k]),
         .evt          (k_evt[k])
      );
   end

   logic sel;
   assign sel = req_write;

   smt_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLOAT_W(FLOAT_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .cs_on      (k_cs_on[sel]),
      .cs_off     (k_cs_off[sel]),
      .st_on      (k_st_on[sel]),
      .st_off     (k_st_off[sel]),
      .last       (k_last[sel]),
      .evt        (k_evt[sel]),
      .float_ticks(float_ticks),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .mem_addr   (mem_addr),
      .mem_dout   (mem_dout),
      .mem_dout_en(mem_dout_en),
      .mem_din    (mem_din),
      .mem_cs_n   (mem_cs_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n)
   );

endmodule

// File: rtl/sram_strobe_ctl_chk.sv
module sram_strobe_ctl_chk #(
   parameter int DATA_W  = 8,
   parameter int PULSE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [2:0]        cfg_addr,
   input logic [15:0]       cfg_wdata,
   input logic              cfg_err,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dout_en,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n
);

   a_r11_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dout_en && !mem_oe_n));

   a_r2_one_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r7_data_held_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dout_en && $stable(mem_dout)));

   a_r7_data_held_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_cs_n) && $past(mem_dout_en)) |-> (mem_dout_en && $stable(mem_dout)));

   a_r9_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r5_rsp_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r4_zero_pulse_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_addr == 3'd1 || cfg_addr == 3'd4) && cfg_wdata[PULSE_W-1:0] == '0)
      |=> cfg_err);

endmodule

bind sram_strobe_ctl sram_strobe_ctl_chk #(
   .DATA_W(DATA_W), .PULSE_W(PULSE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .cfg_err    (cfg_err),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_dout   (mem_dout),
   .mem_dout_en(mem_dout_en),
   .mem_cs_n   (mem_cs_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n)
);

// File: tb/sram_strobe_ctl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctl_bench;

   localparam int ADDR_W = 19;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [2:0]        cfg_addr = '0;
   logic [15:0]       cfg_wdata = '0;
   logic              cfg_err;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_dout;
   logic              mem_dout_en;
   logic [DATA_W-1:0] mem_din;
   logic              mem_cs_n, mem_oe_n, mem_we_n;

   always #4 clk = ~clk;

   sram_strobe_ctl u_sram_strobe_ctl (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
   );

   // memory model: address XOR ticks spent with output enable low
   logic [7:0] lowcnt = 8'd0;
   always @(posedge clk) lowcnt <= mem_oe_n ? 8'd0 : lowcnt + 8'd1;
   assign mem_din = mem_oe_n ? 8'hEE : (mem_addr[7:0] ^ lowcnt);

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic cfg_write(input int idx, input int val);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_addr  = 3'(idx);
      cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic run_access(input bit wr, input int a, input int d,
                             input int cs_s, input int cs_p, input int st_s, input int st_p,
                             input int cyc_f, input bit smode, input int flt);
      int base, csp, stp, cs_off, st_off, cyc, span, last, evt, f, erd, mode;
      bit ecs, est;
      base = wr ? 3 : 0;
      mode = flt & 15;
      if (wr) mode = mode | (int'(smode) << 9) | (1 << 8);
      else    mode = mode | (1 << 9) | (int'(smode) << 8);
      // R12 register layout
      cfg_write(base,     (cs_s << 8) | st_s);
      cfg_write(base + 1, (cs_p << 8) | st_p);
      cfg_write(base + 2, cyc_f);
      cfg_write(wr ? 1 : 4, (1 << 8) | 1);
      cfg_write(6, mode);
      chk(cfg_err == (cs_p == 0 || st_p == 0), "R4", "cfg_err", int'(cfg_err),
          int'(cs_p == 0 || st_p == 0));

      csp    = (cs_p == 0) ? 1 : cs_p;
      stp    = (st_p == 0) ? 1 : st_p;
      cs_off = cs_s + csp;
      st_off = st_s + stp;
      cyc    = ((cyc_f >> 7) & 3) * 256 + (cyc_f & 127);
      span   = cyc;
      if (cs_off > span) span = cs_off;
      if (st_off > span) span = st_off;
      last   = span - 1;
      evt    = smode ? st_off - 1 : cs_off - 1;
      f      = wr ? 0 : (flt & 15);
      erd    = (evt >= st_s && evt < st_off) ? ((a & 255) ^ (evt - st_s)) : 'hEE;

      chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = ADDR_W'(a);
      req_wdata = DATA_W'(d);
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t <= last + 1 + f; t++) begin
         if (t > 0) @(negedge clk);
         ecs = !(t >= cs_s && t < cs_off);
         est = !(t >= st_s && t < st_off);
         chk(mem_cs_n == ecs, wr ? "R2" : "R1", "cs_n", int'(mem_cs_n), int'(ecs));
         if (wr) begin
            chk(mem_we_n == est, "R2", "we_n", int'(mem_we_n), int'(est));
            chk(mem_oe_n == 1'b1, "R2", "oe_n during write", int'(mem_oe_n), 1);
            chk(rsp_valid == (t == evt + 1), "R6", "write done pulse",
                int'(rsp_valid), int'(t == evt + 1));
            chk(mem_dout_en == (t <= last + 1), "R7", "dout_en",
                int'(mem_dout_en), int'(t <= last + 1));
            if (t <= last + 1)
               chk(mem_dout == DATA_W'(d), "R7", "dout", int'(mem_dout), d & 255);
         end else begin
            chk(mem_oe_n == est, "R1", "oe_n", int'(mem_oe_n), int'(est));
            chk(mem_we_n == 1'b1, "R1", "we_n during read", int'(mem_we_n), 1);
            chk(rsp_valid == (t == evt + 1), "R5", "read valid pulse",
                int'(rsp_valid), int'(t == evt + 1));
            if (t == evt + 1)
               chk(rsp_rdata == DATA_W'(erd), "R5", "read data", int'(rsp_rdata), erd);
            chk(mem_dout_en == 1'b0, "R11", "dout_en during read", int'(mem_dout_en), 0);
         end
         if (t <= last)
            chk(mem_addr == ADDR_W'(a), "R7", "addr held", int'(mem_addr), a);
         chk(req_ready == (t == last + 1 + f), wr ? "R3,R9" : "R3,R8", "ready",
             int'(req_ready), int'(t == last + 1 + f));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_oe_n && mem_we_n, "R10", "strobes in reset",
          int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
      chk(!mem_dout_en && !rsp_valid, "R10", "dout_en/rsp in reset",
          int'({mem_dout_en, rsp_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
      chk(cfg_err == 1'b0, "R10", "cfg_err after reset", int'(cfg_err), 0);

      // zero-setup reads and writes with pulse filling the cycle
      run_access(1'b0, 'h123, 0,    0, 6, 0, 6, 6, 1'b1, 3);
      run_access(1'b1, 'h2A5, 'h5A, 0, 5, 0, 5, 6, 1'b1, 3);
      run_access(1'b0, 'h2A5, 0,    0, 5, 0, 5, 6, 1'b0, 0);

      // sweep of small timings, both modes, both kinds
      for (int wr = 0; wr < 2; wr++)
         for (int cs_s = 0; cs_s < 3; cs_s++)
            for (int cs_p = 0; cs_p < 3; cs_p++)
               for (int st_s = 0; st_s < 3; st_s++)
                  for (int st_p = 0; st_p < 4; st_p++)
                     for (int sm = 0; sm < 2; sm++)
                        for (int ci = 0; ci < 2; ci++)
                           run_access(bit'(wr), (cs_s * 37 + st_p * 11 + ci) & 'h7FFFF,
                                      (cs_p * 53 + st_s * 17 + sm) & 255,
                                      cs_s, cs_p, st_s, st_p, ci ? 7 : 0, bit'(sm),
                                      (cs_s + st_p + ci) % 4);

      // split cycle encoding, upper bits weighted by 256
      run_access(1'b0, 'h0F0, 0,    1, 2, 0, 3, 'h181, 1'b1, 2);
      run_access(1'b1, 'h0F1, 'hC3, 0, 1, 2, 4, 'h0FF, 1'b0, 5);
      run_access(1'b0, 'h0F2, 0,    3, 0, 1, 0, 'h100, 1'b0, 1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule